// File: doc/BRIEF.md
# Programmable Reference Divider with Shaped Pulse Output

This block divides a reference clock by a 15-bit ratio and produces one narrow high pulse per division period, which feeds a phase/frequency detector. A down-counter is clocked by the rising edges of the reference. When it reaches its terminal count it reloads the ratio and starts a pulse. The pulse rises on a reference rising edge and falls on a later reference falling edge, so it is exactly four and a half input cycles wide.

A ratio of one selects a bypass path: the counter and the shaper step aside, and the reference clock itself appears at the output. Software writes a new ratio through a value bus and a load strobe. Illegal values are dropped. A legal value waits until the current period ends, so no period is ever cut short or stretched by a ratio change. An output enable gates the result to a steady low. Reset leaves the output disabled.

Top module: `ref_pulse_div`

## Requirements
- R1: With an active legal ratio N (5 to 32767), the output pulse repeats every N reference clock cycles.
- R2: In divide mode the pulse rises on a reference rising edge and falls on a reference falling edge. It stays high for 4.5 reference cycles each period.
- R3: An active ratio of 1 is bypass mode. While enabled, the output equals the reference clock: period one cycle, high time half a cycle.
- R4: The enable input is sampled on reference rising edges. While the sampled enable is 0, the output holds a steady low.
- R5: Reset clears the sampled enable, so the output stays low, and sets the active ratio to the default of 5.
- R6: A load of the value 0, 2, 3 or 4 is ignored, and the previous ratio stays in force.
- R7: A newly loaded legal ratio first applies to the period that starts at the next terminal count. The period already running keeps its old length.
- R8: A ratio value is captured on a reference rising edge where the load strobe is 1. It is not captured when the strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the counter steps on its rising edges |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_i | input | 15 | Division ratio to load |
| ratio_ld_i | input | 1 | Load strobe for ratio_i |
| out_en_i | input | 1 | Output enable; 0 forces the output low |
| pulse_o | output | 1 | Divided pulse, or the reference clock in bypass mode |

## Verification
The assertions check several behaviours on every cycle:
- the counter steps down by one between terminal counts, and reloads to the active ratio at each terminal count;
- the active ratio holds still between terminal counts;
- only legal values reach the pending ratio register, and illegal loads leave it unchanged;
- the rising-edge part of the pulse lasts exactly four cycles;
- the output stays low while the enable is off.

Other behaviours only the bench's scenarios can show, because it measures times at the output pin:
- the half-cycle term of the pulse width, which comes from the falling-edge register;
- the true periods at the extreme ratios 5 and 32767 and in bypass;
- that a ratio loaded in mid-period leaves that period's length unchanged.

// File: rtl/ref_pulse_div_pkg.sv
package ref_pulse_div_pkg;
  // Number of whole reference cycles the rising-edge half of the pulse lasts.
  // The falling-edge stage adds the final half cycle.
  localparam int unsigned PULSE_FULL_CYC = 4;
  // The ratio value that selects the bypass path.
  localparam int unsigned BYPASS_RATIO   = 1;
endpackage

// File: rtl/ref_pulse_div_rst_sync.sv
module ref_pulse_div_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[i] <= 1'b0;
          else         sync_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ref_pulse_div_ratio_ctl.sv
module ref_pulse_div_ratio_ctl
  import ref_pulse_div_pkg::*;
#(
  parameter int unsigned RATIO_W     = 15,
  parameter int unsigned MIN_RATIO   = 5,
  parameter int unsigned RESET_RATIO = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               ld_i,
  input  logic               tc_i,
  output logic [RATIO_W-1:0] pend_o,
  output logic [RATIO_W-1:0] act_o,
  output logic               bypass_o,
  output logic               pend_bypass_o
);
  localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] BYP_V = RATIO_W'(BYPASS_RATIO);
  localparam logic [RATIO_W-1:0] RST_V = RATIO_W'(RESET_RATIO);

  logic [RATIO_W-1:0] pend_q, pend_d;
  logic [RATIO_W-1:0] act_q, act_d;
  logic               legal;
  logic               pend_en, act_en;

  always_comb begin
    legal   = (ratio_i == BYP_V) || (ratio_i >= MIN_V);
    pend_en = ld_i && legal;
    act_en  = tc_i;
    pend_d  = ratio_i;
    act_d   = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_V;
      act_q  <= RST_V;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign pend_o        = pend_q;
  assign act_o         = act_q;
  assign bypass_o      = (act_q == BYP_V);
  assign pend_bypass_o = (pend_q == BYP_V);
endmodule

// File: rtl/ref_pulse_div_count.sv
module ref_pulse_div_count #(
  parameter int unsigned RATIO_W     = 15,
  parameter int unsigned RESET_RATIO = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] reload_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic               tc_o
);
  localparam logic [RATIO_W-1:0] RST_V = RATIO_W'(RESET_RATIO);
  localparam logic [RATIO_W-1:0] ONE_V = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               tc;

  always_comb begin
    tc    = (cnt_q <= ONE_V);
    cnt_d = tc ? reload_i : (cnt_q - ONE_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_V;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc;
endmodule

// File: rtl/ref_pulse_div_shaper.sv
module ref_pulse_div_shaper
  import ref_pulse_div_pkg::*;
#(
  parameter int unsigned HIGH_CYC = PULSE_FULL_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic rise_part_o,
  output logic shaped_o
);
  localparam int unsigned HW = $clog2(HIGH_CYC + 1);
  localparam logic [HW-1:0] LAST_V = HW'(HIGH_CYC - 1);

  logic          p_q, p_d;
  logic [HW-1:0] h_q, h_d;
  logic          n_q;

  always_comb begin
    p_d = p_q;
    h_d = h_q;
    if (start_i) begin
      p_d = 1'b1;
      h_d = LAST_V;
    end else if (p_q) begin
      if (h_q == '0) p_d = 1'b0;
      else           h_d = h_q - HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      h_q <= '0;
    end else begin
      p_q <= p_d;
      h_q <= h_d;
    end
  end

  // Falling-edge copy stretches the pulse by half a reference cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= 1'b0;
    else        n_q <= p_q;
  end

  assign rise_part_o = p_q;
  assign shaped_o    = p_q | n_q;
endmodule

// File: rtl/ref_pulse_div.sv
module ref_pulse_div
  import ref_pulse_div_pkg::*;
#(
  parameter int unsigned RATIO_W     = 15,
  parameter int unsigned MIN_RATIO   = 5,
  parameter int unsigned RESET_RATIO = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               arst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               ratio_ld_i,
  input  logic               out_en_i,
  output logic               pulse_o
);
  logic               rst_sync_n;
  logic [RATIO_W-1:0] pend_ratio, act_ratio, cnt;
  logic               tc, bypass, pend_bypass;
  logic               start, rise_part, shaped;
  logic               en_q, en_d, en_ce;

  ref_pulse_div_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(ref_clk), .arst_n(arst_n), .rst_n_o(rst_sync_n)
  );

  ref_pulse_div_ratio_ctl #(
    .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
  ) u_ratio (
    .clk(ref_clk), .rst_n(rst_sync_n), .ratio_i(ratio_i), .ld_i(ratio_ld_i),
    .tc_i(tc), .pend_o(pend_ratio), .act_o(act_ratio), .bypass_o(bypass),
    .pend_bypass_o(pend_bypass)
  );

  ref_pulse_div_count #(.RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)) u_cnt (
    .clk(ref_clk), .rst_n(rst_sync_n), .reload_i(pend_ratio),
    .cnt_o(cnt), .tc_o(tc)
  );

  // A pulse only starts when the period beginning at this terminal count divides.
  assign start = tc && !pend_bypass;

  ref_pulse_div_shaper #(.HIGH_CYC(PULSE_FULL_CYC)) u_shape (
    .clk(ref_clk), .rst_n(rst_sync_n), .start_i(start),
    .rise_part_o(rise_part), .shaped_o(shaped)
  );

  always_comb begin
    en_ce = (out_en_i != en_q);
    en_d  = out_en_i;
  end

  always_ff @(posedge ref_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= 1'b0;
    else if (en_ce)  en_q <= en_d;
  end

  assign pulse_o = en_q & (bypass ? ref_clk : shaped);
endmodule

// File: rtl/ref_pulse_div_chk.sv
module ref_pulse_div_chk #(
  parameter int unsigned RATIO_W   = 15,
  parameter int unsigned MIN_RATIO = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               ratio_ld_i,
  input logic [RATIO_W-1:0] pend_ratio,
  input logic [RATIO_W-1:0] act_ratio,
  input logic [RATIO_W-1:0] cnt,
  input logic               tc,
  input logic               rise_part,
  input logic               en_q,
  input logic               pulse_o
);
  logic in_legal;
  assign in_legal = (ratio_i == RATIO_W'(1)) || (ratio_i >= RATIO_W'(MIN_RATIO));

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> cnt == $past(cnt) - RATIO_W'(1)); // R1

  AST_COUNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> cnt == act_ratio); // R1

  AST_RISE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_part) |=> rise_part ##1 rise_part ##1 rise_part ##1 !rise_part); // R2

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pulse_o); // R4

  AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    act_ratio == RATIO_W'(1) || act_ratio >= RATIO_W'(MIN_RATIO)); // R6

  AST_ILLEGAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ld_i && !in_legal |=> $stable(pend_ratio)); // R6

  AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(act_ratio)); // R7

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ld_i && in_legal |=> pend_ratio == $past(ratio_i)); // R8

  AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_ld_i |=> $stable(pend_ratio)); // R8
endmodule

bind ref_pulse_div ref_pulse_div_chk #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_chk (
  .clk(ref_clk), .rst_n(rst_sync_n), .ratio_i(ratio_i), .ratio_ld_i(ratio_ld_i),
  .pend_ratio(pend_ratio), .act_ratio(act_ratio), .cnt(cnt), .tc(tc),
  .rise_part(rise_part), .en_q(en_q), .pulse_o(pulse_o)
);

// File: tb/ref_pulse_div_tb.sv
`timescale 1ns/1ps
module ref_pulse_div_tb;
  localparam real CLK_NS = 20.0;
  localparam int  W      = 15;

  logic         clk = 1'b0;
  logic         arst_n = 1'b0;
  logic [W-1:0] ratio = '0;
  logic         ld = 1'b0;
  logic         en = 1'b0;
  logic         pulse;

  int checks = 0;
  int fails  = 0;
  int cur_ratio = 5;
  longint cycles = 0;

  ref_pulse_div u_dut (
    .ref_clk(clk), .arst_n(arst_n), .ratio_i(ratio), .ratio_ld_i(ld),
    .out_en_i(en), .pulse_o(pulse)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  function automatic bit is_legal(int r);
    return (r == 1) || (r >= 5 && r <= 32767);
  endfunction
  function automatic real exp_period(int r);
    return r * CLK_NS;
  endfunction
  function automatic real exp_high(int r);
    return (r == 1) ? CLK_NS / 2.0 : 4.5 * CLK_NS;
  endfunction
  function automatic bit near(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic check_real(string req, real act, real expv);
    checks++;
    if (!near(act, expv)) begin
      fails++;
      $display("FAIL %s: actual %0.3f ns expected %0.3f ns", req, act, expv);
    end
  endtask

  task automatic load(int r);
    @(negedge clk);
    ratio = W'(r);
    ld    = 1'b1;
    @(negedge clk);
    ld    = 1'b0;
    ratio = W'($urandom);
    if (is_legal(r)) cur_ratio = r;
  endtask

  // Skip one pulse so the new ratio is surely active, then time a full period.
  task automatic measure(string req);
    real t0, th, tp;
    repeat (2) @(posedge pulse);
    t0 = $realtime;
    @(negedge pulse);
    th = $realtime - t0;
    @(posedge pulse);
    tp = $realtime - t0;
    check_real({req, " period"}, tp, exp_period(cur_ratio));
    check_real({req, " high"}, th, exp_high(cur_ratio));
  endtask

  task automatic expect_low(string req, int ncyc);
    int bad = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #2;
      if (pulse !== 1'b0) bad++;
      @(negedge clk); #2;
      if (pulse !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: actual %0d high samples expected 0", req, bad);
    end
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    expect_low("R5 in reset", 3);
    arst_n = 1'b1;
    expect_low("R5 after reset, enable cleared", 20);

    // R5: default ratio 5 after reset, also R1/R2 at the smallest ratio
    en = 1'b1;
    measure("R5 default ratio");

    load(5);
    measure("R1 R2 ratio 5");

    // R4: disabled output rests low
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    expect_low("R4 disabled", 30);
    @(negedge clk); en = 1'b1;

    load(7);
    measure("R1 R2 ratio 7");

    // R6: illegal values are dropped, previous ratio stays
    load(3);
    measure("R6 load 3 ignored");
    load(0);
    load(4);
    load(2);
    measure("R6 loads 0/4/2 ignored");

    // R8: value present without strobe is not captured
    @(negedge clk); ratio = W'(9);
    repeat (20) @(negedge clk);
    measure("R8 no strobe no capture");

    // R7: a load in mid-period leaves the running period unchanged
    begin
      real t0, tp;
      load(40);
      measure("R1 ratio 40");
      @(posedge pulse); t0 = $realtime;
      repeat (3) @(negedge clk);
      ratio = W'(11); ld = 1'b1;
      @(negedge clk); ld = 1'b0;
      @(posedge pulse); tp = $realtime - t0;
      check_real("R7 running period kept", tp, exp_period(40));
      cur_ratio = 11;
      measure("R7 new ratio later");
    end

    // R3: bypass follows the reference clock
    load(1);
    measure("R3 bypass");
    load(6);
    measure("R3 leave bypass ratio 6");

    // Random mix of legal and illegal ratios
    for (int i = 0; i < 8; i++) begin
      int r;
      if ($urandom % 4 == 0) r = ($urandom % 2 == 0) ? 0 : 2 + int'($urandom % 3);
      else                   r = 5 + int'($urandom % 300);
      load(r);
      measure(is_legal(r) ? "R1 R2 random ratio" : "R6 random illegal");
    end

    // R1: largest ratio
    load(32767);
    measure("R1 R2 ratio 32767");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule